// File: doc/BRIEF.md
# Handshaking Bidirectional Parallel Port

This block is one 8-bit peripheral port that sits on a processor's register bus. Each pin has its own direction bit. Pins set as outputs are driven from an output register. Pins set as inputs are read back through a two-flop synchronizer. Two control lines go with the port:

- **Strobe input** (`ctl1_i`): sensitive to an edge, and the active polarity is programmable. An active edge raises an interrupt flag. It can also freeze the port's read view, so that the processor sees the data that was present when the strobe arrived.
- **Handshake line** (`ctl2_*`): this line has three modes.
  - **Off**: the line is a second edge input with its own flag.
  - **Read handshake**: a processor read of the data register drives a "data taken" signal, active low.
  - **Write handshake**: a processor write of the data register drives a "data ready" signal, active low.

  In both handshake modes the signal is either a one-cycle pulse, or a level that stays low until the next active strobe edge releases it.

Each of the two flags has an enable bit. The port's interrupt request is active low and is asserted while any enabled flag is set. The processor reaches four registers through a synchronous select / write-enable / address interface. Reads are combinational within the access cycle. The side effects of an access take hold at the clock edge that ends the cycle.

Register map. The address is 2 bits:

| Address | Register | Write | Read |
|---|---|---|---|
| 0 | DATA | Sets the output register | Returns the port view |
| 1 | DIR | Sets the direction bits | Returns the direction bits |
| 2 | CTRL | Sets the control fields below | Returns the control fields |
| 3 | IRQ | 1 in bit 0 or bit 1 clears that flag; bits 5:4 load the enables (bit 4 = strobe, bit 5 = handshake line) | {0,0, enables[1:0], 0,0, flags[1:0]} |

CTRL fields:

| Bit(s) | Meaning |
|---|---|
| 0 | Strobe active on the rising edge (0 = falling) |
| 1 | Latch enable |
| 3:2 | Handshake mode: 0 = off, 1 = read handshake, 2 or 3 = write handshake |
| 4 | Pulse form (0 = level) |
| 5 | Handshake line, in off mode, active on the rising edge |

Top module: `hsk_pport`

## Requirements
- R1: `pin_oe` equals the direction register (bit = 1 means output) and `pin_o` equals the output register, both updated at the edge that ends a write to address 1 or address 0.
- R2: With latching off, a read of address 0 returns the synchronized pin levels for input bits and the output register bits for output bits; a pin change shows up in reads two clock edges later.
- R3: With CTRL bit 1 set, the edge that sets the strobe flag captures the port view, and reads of address 0 return that capture while the strobe flag stays set.
- R4: An active strobe edge (polarity from CTRL bit 0) sets flag 0 on the third clock edge after the input change; the inactive edge sets nothing.
- R5: Any read or write of address 0 clears both flags; writing IRQ with a 1 in bit 0 or bit 1 clears that flag; a flag being set in the same cycle as it is cleared stays set.
- R6: In write-handshake level form, a write of address 0 drives `ctl2_o` low from the next edge, and it stays low until an active strobe edge raises it, three edges after the strobe change.
- R7: In pulse form, the address 0 access that triggers the handshake (a write in write mode, a read in read mode) drives `ctl2_o` low for exactly one cycle.
- R8: In read-handshake level form, a read of address 0 drives `ctl2_o` low until the next active strobe edge.
- R9: In off mode, `ctl2_oe` is 0 and an active edge on `ctl2_i` (polarity from CTRL bit 5) sets flag 1; `irq_n` is low exactly while some flag is set together with its enable.
- R10: After reset, every register is 0: all pins are inputs, `ctl2_oe` is 0, `ctl2_o` is 1 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register access in this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data (0 when not reading) |
| pin_i | input | WIDTH | Pin levels seen from outside |
| pin_o | output | WIDTH | Pin drive values |
| pin_oe | output | WIDTH | Pin drive enables |
| ctl1_i | input | 1 | Strobe control input |
| ctl2_i | input | 1 | Handshake line level from outside |
| ctl2_o | output | 1 | Handshake line drive value (active low) |
| ctl2_oe | output | 1 | Handshake line drive enable |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The timing of each result is fixed:

- A register access changes `pin_o`, `pin_oe` and `ctl2_o` at the one edge that ends the access.
- A pin change reaches the read data after two edges.
- A control-line change reaches the flags, `irq_n`, the capture and the level release after three edges.

The bench drives every stimulus on a falling clock edge and samples on falling edges, counting exactly that many rising edges between the two. For each timed result, it checks that the output is still unchanged one edge before it is due and has changed on the edge it is due. A pulse is checked low on its one cycle and high on the next.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_CTRL = 2'd2,
    REG_IRQ  = 2'd3
  } hsp_reg_e;

  typedef enum logic [1:0] {
    HS_OFF   = 2'd0,
    HS_READ  = 2'd1,
    HS_WRITE = 2'd2,
    HS_WRALT = 2'd3
  } hs_mode_e;

  // packed MSB first: bit5 ctl2_rise ... bit0 ctl1_rise
  typedef struct packed {
    logic     ctl2_rise;
    logic     pulse;
    hs_mode_e mode;
    logic     latch_en;
    logic     ctl1_rise;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/hsp_edge.sv
module hsp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  output logic hit
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign hit = rise_sel ? (lvl & ~prev_q) : (~lvl & prev_q);

endmodule

// File: rtl/hsp_handshake.sv
module hsp_handshake
  import hsp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hs_mode_e mode,
  input  logic     pulse,
  input  logic     data_rd,
  input  logic     data_wr,
  input  logic     release_hit,
  output logic     ctl_o,
  output logic     ctl_oe
);

  logic lvl_q, lvl_n, lvl_en;
  logic pls_q, pls_n;
  logic trig;

  always_comb begin
    unique case (mode)
      HS_OFF:   trig = 1'b0;
      HS_READ:  trig = data_rd;
      default:  trig = data_wr;
    endcase
  end

  always_comb begin
    lvl_en = 1'b1;
    lvl_n  = lvl_q;
    if (mode == HS_OFF || pulse) lvl_n = 1'b1;
    else if (trig)               lvl_n = 1'b0;
    else if (release_hit)        lvl_n = 1'b1;
    else                         lvl_en = 1'b0;
    pls_n = trig & pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      pls_q <= 1'b0;
    end else begin
      if (lvl_en) lvl_q <= lvl_n;
      pls_q <= pls_n;
    end
  end

  assign ctl_oe = (mode != HS_OFF);
  assign ctl_o  = ~ctl_oe | (lvl_q & ~pls_q);

endmodule

// File: rtl/hsk_pport.sv
module hsk_pport
  import hsp_pkg::*;
#(
  parameter int  WIDTH        = 8,
  parameter int  SYNC_STAGES  = 2,
  parameter bit  OUT_READBACK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe,
  input  logic             ctl1_i,
  input  logic             ctl2_i,
  output logic             ctl2_o,
  output logic             ctl2_oe,
  output logic             irq_n
);

  localparam int NCTL = 2;

  logic [WIDTH-1:0] out_q, out_n;
  logic [WIDTH-1:0] dir_q, dir_n;
  logic [WIDTH-1:0] lat_q, lat_n;
  ctrl_t            ctrl_q, ctrl_n;
  logic [NCTL-1:0]  en_q, en_n;
  logic [NCTL-1:0]  flag_q, flag_n;
  logic             out_en, dir_en, ctrl_en, en_en, lat_en;

  logic             rd_acc, wr_acc, data_rd, data_wr;
  hsp_reg_e         reg_sel;
  logic [WIDTH-1:0] pin_s, live_view, port_view;
  logic [NCTL-1:0]  ctl_s, ctl_hit, rise_sel, hit_use, clr;

  assign reg_sel = hsp_reg_e'(addr);
  assign rd_acc  = sel & ~wr_en;
  assign wr_acc  = sel &  wr_en;
  assign data_rd = rd_acc & (reg_sel == REG_DATA);
  assign data_wr = wr_acc & (reg_sel == REG_DATA);

  // ---------------- input synchronizers and edge detect ----------------
  hsp_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
  );

  hsp_sync #(.W(NCTL), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({ctl2_i, ctl1_i}), .q(ctl_s)
  );

  assign rise_sel = {ctrl_q.ctl2_rise, ctrl_q.ctl1_rise};

  generate
    for (genvar c = 0; c < NCTL; c++) begin : g_edge
      hsp_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ctl_s[c]),
        .rise_sel(rise_sel[c]), .hit(ctl_hit[c])
      );
    end
  endgenerate

  // handshake line only reports edges while it is an input
  assign hit_use = {ctl_hit[1] & (ctrl_q.mode == HS_OFF), ctl_hit[0]};

  // ---------------- read view ----------------
  generate
    if (OUT_READBACK) begin : g_rb
      assign live_view = (dir_q & out_q) | (~dir_q & pin_s);
    end else begin : g_pin
      assign live_view = pin_s;
    end
  endgenerate

  assign port_view = (ctrl_q.latch_en & flag_q[0]) ? lat_q : live_view;

  // ---------------- next state ----------------
  always_comb begin
    out_en  = data_wr;
    out_n   = wdata;
    dir_en  = wr_acc & (reg_sel == REG_DIR);
    dir_n   = wdata;
    ctrl_en = wr_acc & (reg_sel == REG_CTRL);
    ctrl_n  = ctrl_t'(wdata[CTRL_W-1:0]);
    en_en   = wr_acc & (reg_sel == REG_IRQ);
    en_n    = wdata[5:4];

    clr = '0;
    if (data_rd | data_wr)                 clr = '1;
    else if (wr_acc && reg_sel == REG_IRQ) clr = wdata[1:0];

    flag_n = (flag_q & ~clr) | hit_use;

    lat_en = hit_use[0] & (~flag_q[0] | clr[0]);
    lat_n  = live_view;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      ctrl_q <= '0;
      en_q   <= '0;
      flag_q <= '0;
      lat_q  <= '0;
    end else begin
      if (out_en)  out_q  <= out_n;
      if (dir_en)  dir_q  <= dir_n;
      if (ctrl_en) ctrl_q <= ctrl_n;
      if (en_en)   en_q   <= en_n;
      if (lat_en)  lat_q  <= lat_n;
      flag_q <= flag_n;
    end
  end

  // ---------------- handshake line ----------------
  hsp_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .pulse(ctrl_q.pulse),
    .data_rd(data_rd), .data_wr(data_wr), .release_hit(hit_use[0]),
    .ctl_o(ctl2_o), .ctl_oe(ctl2_oe)
  );

  // ---------------- outputs ----------------
  always_comb begin
    rdata = '0;
    if (rd_acc) begin
      unique case (reg_sel)
        REG_DATA: rdata = port_view;
        REG_DIR:  rdata = dir_q;
        REG_CTRL: rdata = WIDTH'(ctrl_q);
        REG_IRQ:  rdata = WIDTH'({en_q, 2'b00, flag_q});
      endcase
    end
  end

  assign pin_o  = out_q;
  assign pin_oe = dir_q;
  assign irq_n  = ~|(flag_q & en_q);

endmodule

// File: rtl/hsp_port_chk.sv
module hsp_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe,
  input logic             ctl2_o,
  input logic             irq_n,
  input logic             pulse_mode
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: direction only moves after a direction write
  assert_dir_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(sel && wr_en && addr == 2'd1) |-> $stable(pin_oe));

  // R1: drive values only move after a data write
  assert_out_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(sel && wr_en && addr == 2'd0) |-> $stable(pin_o));

  // R6: handshake line only falls after a data register access
  assert_hs_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $fell(ctl2_o) |-> $past(sel && addr == 2'd0));

  // R7: a pulse lasts one cycle unless retriggered
  assert_pulse_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && pulse_mode && $past(pulse_mode) && !$past(ctl2_o)
    && !$past(sel && addr == 2'd0) |-> ctl2_o);

  // R9: clearing all enables releases the request
  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(sel && wr_en && addr == 2'd3 && wdata[5:4] == 2'b00) |-> irq_n);

endmodule

bind hsk_pport hsp_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .pin_o(pin_o), .pin_oe(pin_oe), .ctl2_o(ctl2_o),
  .irq_n(irq_n), .pulse_mode(ctrl_q.pulse)
);

// File: tb/hsk_pport_test.sv
`timescale 1ns/1ps
module hsk_pport_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         sel = 1'b0, wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, pin_o, pin_oe;
  logic [W-1:0] pin_i = '0;
  logic         ctl1_i = 1'b1, ctl2_i = 1'b1;
  logic         ctl2_o, ctl2_oe, irq_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hsk_pport #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe(pin_oe), .ctl1_i(ctl1_i), .ctl2_i(ctl2_i), .ctl2_o(ctl2_o),
    .ctl2_oe(ctl2_oe), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    check("R10 pin_oe", pin_oe, 0);
    check("R10 pin_o", pin_o, 0);
    check("R10 ctl2_oe", ctl2_oe, 0);
    check("R10 ctl2_o", ctl2_o, 1);
    check("R10 irq_n", irq_n, 1);
    bus_rd(2'd2, d); check("R10 ctrl", d, 0);
    bus_rd(2'd3, d); check("R10 irq reg", d, 0);
  endtask

  task automatic t_dir_out;
    bus_wr(2'd1, 8'hF0);
    check("R1 pin_oe", pin_oe, 8'hF0);
    bus_wr(2'd0, 8'hA5);
    check("R1 pin_o", pin_o, 8'hA5);
  endtask

  task automatic t_live_read;
    logic [W-1:0] d;
    @(negedge clk); pin_i = 8'h3C;
    idle(2);
    bus_rd(2'd0, d); check("R2 mixed view", d, 8'hAC);
    @(negedge clk); pin_i = 8'hC3;
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b0; addr = 2'd0; #1;
    check("R2 one edge early", rdata, 8'hAC);
    @(negedge clk); #1;
    check("R2 two edges", rdata, 8'hA3);
    sel = 1'b0;
  endtask

  task automatic t_strobe_flag;
    logic [W-1:0] d;
    bus_wr(2'd3, 8'h13);           // clear both, enable flag 0
    @(negedge clk); ctl1_i = 1'b0; // falling = active
    @(negedge clk); check("R4 edge+1", irq_n, 1);
    @(negedge clk); check("R4 edge+2", irq_n, 1);
    @(negedge clk); check("R4 edge+3 irq", irq_n, 0);
    bus_rd(2'd3, d); check("R4 flag0 set", d, 8'h11);
    ctl1_i = 1'b1; idle(4);
    check("R4 inactive edge", irq_n, 0);
    bus_rd(2'd0, d);
    check("R5 data read clears", irq_n, 1);
    @(negedge clk); ctl1_i = 1'b0; idle(4);
    check("R9 irq low", irq_n, 0);
    bus_wr(2'd3, 8'h00);
    check("R9 masked", irq_n, 1);
    bus_wr(2'd3, 8'h10);
    check("R9 re-enabled", irq_n, 0);
    bus_wr(2'd3, 8'h11);
    check("R5 w1c clears", irq_n, 1);
    ctl1_i = 1'b1; idle(4);
  endtask

  task automatic t_latch;
    logic [W-1:0] d;
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd2, 8'h02);
    @(negedge clk); pin_i = 8'h55; idle(3);
    ctl1_i = 1'b0; idle(4);
    pin_i = 8'hAA; idle(4);
    bus_rd(2'd0, d); check("R3 held capture", d, 8'h55);
    bus_rd(2'd0, d); check("R3 live after clear", d, 8'hAA);
    ctl1_i = 1'b1; idle(4);
  endtask

  task automatic t_wr_level;
    bus_wr(2'd2, 8'h08);
    check("R6 oe on", ctl2_oe, 1);
    check("R6 idle high", ctl2_o, 1);
    bus_wr(2'd0, 8'h11);
    check("R6 ready low", ctl2_o, 0);
    idle(5);
    check("R6 held low", ctl2_o, 0);
    ctl1_i = 1'b0;
    idle(2); check("R6 not yet released", ctl2_o, 0);
    idle(1); check("R6 released", ctl2_o, 1);
    ctl1_i = 1'b1; idle(4);
    bus_wr(2'd3, 8'h13);
  endtask

  task automatic t_pulses;
    logic [W-1:0] d;
    bus_wr(2'd2, 8'h18);
    bus_wr(2'd0, 8'h22);
    check("R7 write pulse low", ctl2_o, 0);
    idle(1); check("R7 write pulse end", ctl2_o, 1);
    bus_rd(2'd0, d);
    check("R7 read no pulse in write mode", ctl2_o, 1);
    bus_wr(2'd2, 8'h14);
    bus_rd(2'd0, d);
    check("R7 read pulse low", ctl2_o, 0);
    idle(1); check("R7 read pulse end", ctl2_o, 1);
  endtask

  task automatic t_rd_level;
    logic [W-1:0] d;
    bus_wr(2'd2, 8'h04);
    bus_wr(2'd0, 8'h33);
    check("R8 write ignored", ctl2_o, 1);
    bus_rd(2'd0, d);
    check("R8 taken low", ctl2_o, 0);
    idle(4); check("R8 held", ctl2_o, 0);
    ctl1_i = 1'b0; idle(3);
    check("R8 released", ctl2_o, 1);
    ctl1_i = 1'b1; idle(4);
    bus_wr(2'd3, 8'h13);
  endtask

  task automatic t_ctl2_input;
    logic [W-1:0] d;
    bus_wr(2'd2, 8'h20);
    check("R9 oe off", ctl2_oe, 0);
    bus_wr(2'd3, 8'h23);
    @(negedge clk); ctl2_i = 1'b0; idle(4);
    check("R9 inactive ctl2 edge", irq_n, 1);
    ctl2_i = 1'b1;
    idle(2); check("R9 ctl2 edge+2", irq_n, 1);
    idle(1); check("R9 ctl2 edge+3", irq_n, 0);
    bus_rd(2'd3, d); check("R9 flag1 set", d, 8'h22);
  endtask

  task automatic t_rise_pol;
    logic [W-1:0] d;
    bus_wr(2'd2, 8'h01);
    bus_wr(2'd3, 8'h13);
    @(negedge clk); ctl1_i = 1'b0; idle(5);
    check("R4 falling ignored", irq_n, 1);
    ctl1_i = 1'b1; idle(3);
    check("R4 rising active", irq_n, 0);
    bus_rd(2'd3, d); check("R4 rising flag", d, 8'h11);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_dir_out();
    t_live_read();
    t_strobe_flag();
    t_latch();
    t_wr_level();
    t_pulses();
    t_rd_level();
    t_ctl2_input();
    t_rise_pol();
    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule